// File: doc/BRIEF.md
# Audio Clock Ratio and Speed-Mode Detector

This block sits in the master-clock (MCLK) domain of an audio converter. It measures how many master-clock cycles fit into one period of the frame clock (LRCK), which runs at the per-channel sample rate Fs. It also measures the absolute master-clock rate against a free-running reference clock of known frequency. From these two numbers it decides whether the stream is single-, double- or quad-speed. A master-clock/frame-clock ratio such as 256 is legal in all three modes, so the ratio alone cannot tell the modes apart.

Detection starts on a start request. The frame clock passes through a synchronizer, and the first, partial frame after the request is thrown away. The block locks once two consecutive whole frames agree and a full rate window has been seen. When locked, it reports a ratio code, a speed-mode code and a master-clock divide factor for downstream clock generation. This divide factor reaches an internal clock of 128·Fs in single speed, 64·Fs in double speed and 32·Fs in quad speed. A ratio that is not legal for the detected mode raises an error flag and keeps lock low. A frame longer than a 12-bit count also raises the error flag and keeps lock low.

Top module: `clk_ratio_detect`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `locked`=0, `err`=0, `ratio_code`=15, `speed_mode`=0 and `div_sel`=0.
- R2: Before the first `start` pulse after reset, `locked` stays 0 however long LRCK runs.
- R3: The ratio is the number of MCLK cycles between two successive LRCK rising edges. `locked` rises only after two consecutive whole frames give the same ratio and a full reference window has completed after `start`. `ratio_code` encodes 64,96,128,192,256,384,512,768,1024,1152 as 0..9, and any other ratio as 15.
- R4: `speed_mode` is 1 (single), 2 (double) or 3 (quad). Let F be the number of MCLK cycles counted in a window of WIN_REF reference cycles, and R the ratio. The mode is quad when F ≥ R·QS_FPW, double when F ≥ R·DS_FPW, and single otherwise.
- R5: The same ratio (256) is reported with different speed modes when the MCLK rate differs.
- R6: A ratio outside the legal set of its mode sets `err`=1 with `locked`=0. The legal sets are: single 256–1152 (codes 4..9), double 128–512 (codes 2..6), quad 64–256 (codes 0..4). A non-standard ratio (code 15) is never legal.
- R7: If a frame reaches 4095 MCLK cycles without an LRCK rising edge, `err` goes to 1 and `locked` to 0.
- R8: After lock, a frame whose ratio differs from the locked one drops `locked`. Detection then restarts and locks again to the new ratio.
- R9: When locked, `div_sel` = R/128 in single speed, R/64 in double speed and R/32 in quad speed.
- R10: A `start` pulse clears `locked` and `err` on the next clock edge.
- R11: Whenever `locked` is 0, `ratio_code`=15, `speed_mode`=0 and `div_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; all outputs are in this domain |
| ref_clk | input | 1 | Free-running reference clock of known frequency |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| lrck | input | 1 | Frame clock, synchronous to mclk, any phase |
| start | input | 1 | One-cycle request to (re)start detection |
| ratio_code | output | 4 | Encoded MCLK/LRCK ratio, 15 when not locked |
| speed_mode | output | 2 | 1 single, 2 double, 3 quad, 0 when not locked |
| locked | output | 1 | Detection result valid |
| err | output | 1 | Illegal ratio for mode or frame-count overflow |
| div_sel | output | 4 | MCLK divide factor to the internal oversampling clock |

## Verification
The assertions watch, on every cycle, the invariants between the outputs. Lock and error never coincide. The codes are cleared while unlocked. A start pulse clears lock and error. Lock rises only on a finished frame measurement. Overflow never coincides with a measurement. Measured periods and window pulses are well formed. Only the bench scenarios can show that the numbers are right. These cover the ratio codes, the mode chosen for a given rate and ratio, the two modes separated at ratio 256, the divide factors, the rejection of illegal and non-standard ratios, relocking after a ratio change and the overflow path.

// File: rtl/clk_det_pkg.sv
`timescale 1ns/1ps
package clk_det_pkg;
  localparam int RATIO_W = 12;
  localparam logic [3:0] CODE_NONE = 4'd15;
  localparam logic [1:0] MODE_NONE = 2'd0;
  localparam logic [1:0] MODE_SS   = 2'd1;
  localparam logic [1:0] MODE_DS   = 2'd2;
  localparam logic [1:0] MODE_QS   = 2'd3;

  function automatic logic [3:0] ratio_to_code(input logic [RATIO_W-1:0] r);
    case (r)
      12'd64:   return 4'd0;
      12'd96:   return 4'd1;
      12'd128:  return 4'd2;
      12'd192:  return 4'd3;
      12'd256:  return 4'd4;
      12'd384:  return 4'd5;
      12'd512:  return 4'd6;
      12'd768:  return 4'd7;
      12'd1024: return 4'd8;
      12'd1152: return 4'd9;
      default:  return CODE_NONE;
    endcase
  endfunction

  // legal code window per mode: single 4..9, double 2..6, quad 0..4
  function automatic logic code_legal(input logic [3:0] c, input logic [1:0] m);
    case (m)
      MODE_SS: return (c >= 4'd4) && (c <= 4'd9);
      MODE_DS: return (c >= 4'd2) && (c <= 4'd6);
      MODE_QS: return c <= 4'd4;
      default: return 1'b0;
    endcase
  endfunction

  // divide to 128*Fs (single), 64*Fs (double), 32*Fs (quad)
  function automatic logic [3:0] ratio_div(input logic [RATIO_W-1:0] r, input logic [1:0] m);
    logic [RATIO_W-1:0] s;
    case (m)
      MODE_SS: s = r >> 7;
      MODE_DS: s = r >> 6;
      MODE_QS: s = r >> 5;
      default: s = '0;
    endcase
    return s[3:0];
  endfunction
endpackage

// File: rtl/lrck_period_meter.sv
`timescale 1ns/1ps
module lrck_period_meter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic          lrck,
  output logic          meas_vld,
  output logic [CW-1:0] meas_val,
  output logic          ovf
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic [2:0]    sync_q;
  logic          rise;
  logic          enabled;
  logic          running;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], lrck};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      enabled  <= 1'b0;
      running  <= 1'b0;
      cnt      <= '0;
      meas_vld <= 1'b0;
      meas_val <= '0;
      ovf      <= 1'b0;
    end else begin
      meas_vld <= 1'b0;
      ovf      <= 1'b0;
      if (arm) begin
        enabled <= 1'b1;
        running <= 1'b0;
        cnt     <= '0;
      end else if (enabled && rise) begin
        if (running) begin
          meas_vld <= 1'b1;
          meas_val <= cnt;
        end
        running <= 1'b1;
        cnt     <= {{(CW-1){1'b0}}, 1'b1};
      end else if (running) begin
        if (cnt == CNT_MAX) begin
          ovf     <= 1'b1;
          running <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7
  meas_ovf_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({meas_vld, ovf}));
  // R3
  min_period_chk: assert property (@(posedge clk) disable iff (rst)
    meas_vld |-> (meas_val >= CW'(2)));
endmodule

// File: rtl/mclk_rate_meter.sv
`timescale 1ns/1ps
module mclk_rate_meter #(
  parameter int WIN_REF = 256,
  parameter int FW      = 16
) (
  input  logic          clk,
  input  logic          ref_clk,
  input  logic          rst,
  output logic          rate_vld,
  output logic [FW-1:0] rate_val
);
  localparam int WW = $clog2(WIN_REF);
  localparam logic [WW-1:0] WIN_LAST = WW'(WIN_REF - 1);
  localparam logic [FW-1:0] F_MAX = '1;

  logic [WW-1:0] wcnt;
  logic          win_tog;

  // reference-domain window timer, one toggle per window
  always_ff @(posedge ref_clk) begin
    if (rst) begin
      wcnt    <= '0;
      win_tog <= 1'b0;
    end else if (wcnt == WIN_LAST) begin
      wcnt    <= '0;
      win_tog <= ~win_tog;
    end else begin
      wcnt <= wcnt + 1'b1;
    end
  end

  logic [2:0]    tog_q;
  logic          win_edge;
  logic [FW-1:0] fcnt;

  always_ff @(posedge clk) begin
    if (rst) tog_q <= '0;
    else     tog_q <= {tog_q[1:0], win_tog};
  end

  assign win_edge = tog_q[1] ^ tog_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt     <= '0;
      rate_vld <= 1'b0;
      rate_val <= '0;
    end else begin
      rate_vld <= 1'b0;
      if (win_edge) begin
        rate_vld <= 1'b1;
        rate_val <= fcnt;
        fcnt     <= {{(FW-1){1'b0}}, 1'b1};
      end else if (fcnt != F_MAX) begin
        fcnt <= fcnt + 1'b1;
      end
    end
  end

  // R4
  rate_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rate_vld |=> !rate_vld);
endmodule

// File: rtl/mode_lock_ctrl.sv
`timescale 1ns/1ps
module mode_lock_ctrl
  import clk_det_pkg::*;
#(
  parameter int CW     = RATIO_W,
  parameter int FW     = 16,
  parameter int DS_FPW = 6,
  parameter int QS_FPW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          meas_vld,
  input  logic [CW-1:0] meas_val,
  input  logic          ovf,
  input  logic          rate_vld,
  input  logic [FW-1:0] rate_val,
  output logic          locked,
  output logic          err,
  output logic [3:0]    ratio_code,
  output logic [1:0]    speed_mode,
  output logic [3:0]    div_sel
);
  localparam int PW = ((CW > FW) ? CW : FW) + 8;

  logic [CW-1:0] prev;
  logic          have_prev;
  logic [1:0]    win_seen;
  logic [FW-1:0] rate_lat;

  logic [PW-1:0] m_ext, r_ext, ds_lim, qs_lim;
  logic [1:0]    cand_mode;
  logic [3:0]    cand_code;
  logic [3:0]    cand_div;
  logic          cand_ok;
  logic          match;
  logic          ready;

  always_comb begin
    m_ext     = PW'(meas_val);
    r_ext     = PW'(rate_lat);
    ds_lim    = m_ext * PW'(DS_FPW);
    qs_lim    = m_ext * PW'(QS_FPW);
    cand_mode = (r_ext >= qs_lim) ? MODE_QS :
                (r_ext >= ds_lim) ? MODE_DS : MODE_SS;
    cand_code = ratio_to_code(meas_val);
    cand_ok   = code_legal(cand_code, cand_mode);
    cand_div  = ratio_div(meas_val, cand_mode);
    match     = have_prev && (meas_val == prev);
    ready     = (win_seen == 2'd2);
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      locked     <= 1'b0;
      err        <= 1'b0;
      ratio_code <= CODE_NONE;
      speed_mode <= MODE_NONE;
      div_sel    <= '0;
      prev       <= '0;
      have_prev  <= 1'b0;
      win_seen   <= '0;
      if (rst) rate_lat <= '0;
    end else begin
      if (rate_vld) begin
        rate_lat <= rate_val;
        if (win_seen != 2'd2) win_seen <= win_seen + 1'b1;
      end
      if (ovf) begin
        err        <= 1'b1;
        locked     <= 1'b0;
        have_prev  <= 1'b0;
        ratio_code <= CODE_NONE;
        speed_mode <= MODE_NONE;
        div_sel    <= '0;
      end else if (meas_vld) begin
        if (locked) begin
          if (meas_val != prev) begin
            locked     <= 1'b0;
            prev       <= meas_val;
            have_prev  <= 1'b1;
            ratio_code <= CODE_NONE;
            speed_mode <= MODE_NONE;
            div_sel    <= '0;
          end
        end else if (!match || !ready) begin
          prev      <= meas_val;
          have_prev <= 1'b1;
        end else if (cand_ok) begin
          locked     <= 1'b1;
          err        <= 1'b0;
          ratio_code <= cand_code;
          speed_mode <= cand_mode;
          div_sel    <= cand_div;
        end else begin
          err       <= 1'b1;
          have_prev <= 1'b0;
        end
      end
    end
  end

  // R6
  lock_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(locked && err));
  // R11
  unlocked_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !locked |-> (ratio_code == CODE_NONE && speed_mode == MODE_NONE && div_sel == 4'd0));
  // R10
  start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (!locked && !err));
  // R3
  lock_on_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(meas_vld));
  // R9
  locked_div_chk: assert property (@(posedge clk) disable iff (rst)
    locked |-> (div_sel != 4'd0 && speed_mode != MODE_NONE));
endmodule

// File: rtl/clk_ratio_detect.sv
`timescale 1ns/1ps
module clk_ratio_detect #(
  parameter int WIN_REF = 256,
  parameter int FW      = 16,
  parameter int DS_FPW  = 6,
  parameter int QS_FPW  = 12
) (
  input  logic       mclk,
  input  logic       ref_clk,
  input  logic       rst,
  input  logic       lrck,
  input  logic       start,
  output logic [3:0] ratio_code,
  output logic [1:0] speed_mode,
  output logic       locked,
  output logic       err,
  output logic [3:0] div_sel
);
  localparam int CW = clk_det_pkg::RATIO_W;

  logic          meas_vld;
  logic [CW-1:0] meas_val;
  logic          ovf;
  logic          rate_vld;
  logic [FW-1:0] rate_val;

  lrck_period_meter #(.CW(CW)) period_i (
    .clk(mclk), .rst(rst), .arm(start), .lrck(lrck),
    .meas_vld(meas_vld), .meas_val(meas_val), .ovf(ovf)
  );

  mclk_rate_meter #(.WIN_REF(WIN_REF), .FW(FW)) rate_i (
    .clk(mclk), .ref_clk(ref_clk), .rst(rst),
    .rate_vld(rate_vld), .rate_val(rate_val)
  );

  mode_lock_ctrl #(.CW(CW), .FW(FW), .DS_FPW(DS_FPW), .QS_FPW(QS_FPW)) ctrl_i (
    .clk(mclk), .rst(rst), .start(start),
    .meas_vld(meas_vld), .meas_val(meas_val), .ovf(ovf),
    .rate_vld(rate_vld), .rate_val(rate_val),
    .locked(locked), .err(err), .ratio_code(ratio_code),
    .speed_mode(speed_mode), .div_sel(div_sel)
  );
endmodule

// File: tb/clk_ratio_detect_tb.sv
`timescale 1ns/1ps
module clk_ratio_detect_tb_top;
  logic mclk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst = 1'b1;
  logic lrck = 1'b0;
  logic start = 1'b0;
  logic [3:0] ratio_code;
  logic [1:0] speed_mode;
  logic locked, err;
  logic [3:0] div_sel;

  int  checks = 0;
  int  errors = 0;
  bit  done = 0;
  real ref_half = 16.0;
  int  lr_ratio = 0;
  int  lr_cnt = 0;

  clk_ratio_detect dut_i (
    .mclk(mclk), .ref_clk(ref_clk), .rst(rst), .lrck(lrck), .start(start),
    .ratio_code(ratio_code), .speed_mode(speed_mode), .locked(locked),
    .err(err), .div_sel(div_sel)
  );

  always #4 mclk = ~mclk;
  initial forever #(ref_half) ref_clk = ~ref_clk;

  // frame clock: each level lasts lr_ratio/2 mclk cycles, 0 freezes it
  initial forever begin
    @(negedge mclk);
    if (lr_ratio > 0) begin
      if (lr_cnt >= lr_ratio/2 - 1) begin
        lrck = ~lrck;
        lr_cnt = 0;
      end else lr_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_code(input int r);
    case (r)
      64: return 0;  96: return 1;  128: return 2;  192: return 3;
      256: return 4; 384: return 5; 512: return 6;  768: return 7;
      1024: return 8; 1152: return 9;
      default: return 15;
    endcase
  endfunction

  function automatic int exp_div(input int r, input int m);
    return (m == 1) ? r/128 : (m == 2) ? r/64 : r/32;
  endfunction

  // reference half period so that a window spans 4/8/16 frames
  function automatic real half_for(input int r, input int m);
    real frames;
    frames = (m == 1) ? 4.0 : (m == 2) ? 8.0 : 16.0;
    return frames * r / 64.0;
  endfunction

  task automatic wait_sig(input int sel, input logic val, input int max, input string req);
    bit seen = 0;
    for (int i = 0; i < max; i++) begin
      @(negedge mclk);
      if ((sel == 0 ? locked : err) == val) begin seen = 1; break; end
    end
    chk(req, int'(seen), 1);
  endtask

  task automatic pulse_start();
    @(negedge mclk) start = 1'b1;
    @(negedge mclk) start = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge mclk);
    chk("R1 locked in reset", locked, 0);
    chk("R1 err in reset", err, 0);
    rst = 1'b0;
    @(negedge mclk);
    chk("R1 ratio_code after reset", ratio_code, 15);
    chk("R11 speed_mode unlocked", speed_mode, 0);
    chk("R11 div_sel unlocked", div_sel, 0);
  endtask

  task automatic t_no_start();
    lr_ratio = 256;
    ref_half = half_for(256, 1);
    repeat (3000) @(negedge mclk);
    chk("R2 no lock before start", locked, 0);
  endtask

  task automatic t_lock(input string req, input int r, input int m);
    lr_ratio = r;
    ref_half = half_for(r, m);
    repeat (50) @(negedge mclk);
    pulse_start();
    wait_sig(0, 1'b1, 60000, {req, " lock reached"});
    chk({req, " R3 ratio_code"}, ratio_code, exp_code(r));
    chk({req, " R4 speed_mode"}, speed_mode, m);
    chk({req, " R9 div_sel"}, div_sel, exp_div(r, m));
    chk({req, " err low"}, err, 0);
  endtask

  task automatic t_change();
    lr_ratio = 128;
    wait_sig(0, 1'b0, 3000, "R8 lock dropped on ratio change");
    chk("R11 code cleared while relocking", ratio_code, 15);
    wait_sig(0, 1'b1, 3000, "R8 relock");
    chk("R8 new ratio_code", ratio_code, exp_code(128));
    chk("R8 mode kept", speed_mode, 3);
    chk("R9 div after change", div_sel, exp_div(128, 3));
  endtask

  task automatic t_illegal(input string req, input int r, input int m);
    lr_ratio = r;
    ref_half = half_for(r, m);
    repeat (50) @(negedge mclk);
    pulse_start();
    wait_sig(1, 1'b1, 60000, {req, " err raised"});
    chk({req, " locked low"}, locked, 0);
    chk({req, " code idle"}, ratio_code, 15);
  endtask

  task automatic t_overflow();
    lr_ratio = 0;
    repeat (4300) @(negedge mclk);
    chk("R7 err on overflow", err, 1);
    chk("R7 lock dropped", locked, 0);
  endtask

  task automatic t_restart();
    lr_ratio = 256;
    pulse_start();
    chk("R10 err cleared by start", err, 0);
    chk("R10 locked cleared by start", locked, 0);
    wait_sig(0, 1'b1, 60000, "R10 relock after start");
    chk("R10 ratio_code", ratio_code, exp_code(256));
  endtask

  initial begin
    t_reset();
    t_no_start();
    t_lock("R3 SS256", 256, 1);
    t_lock("R4 QS64", 64, 3);
    t_lock("R4 DS256", 256, 2);
    t_lock("R3 SS1152", 1152, 1);
    t_lock("R5 QS256", 256, 3);
    t_change();
    t_illegal("R6 DS768", 768, 2);
    t_illegal("R6 R300", 300, 1);
    t_lock("R7 prep SS256", 256, 1);
    t_overflow();
    t_restart();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(190000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule